// File: doc/BRIEF.md
# Multi-register keyed word scrambler

This block scrambles 32-bit data words under a key held in six Galois shift registers. Four long pad registers (160 to 163 bits) form the key material. A 32-bit injector decides how many scrambling steps each word gets, and a 40-bit pad selector decides which pad bit feeds each step. Software or a key source loads all six registers one byte at a time through a configuration port. Afterwards the block takes input words as four bytes, most significant byte first.

Each accepted word is placed in a 32-bit CRC register. On every step, one selected pad bit is shifted into that register, and then all pads and the selector advance. The scrambled word leaves as four bytes, most significant first, through a small output buffer. The consumer drains that buffer with a stop signal. Pad and selector state carry over from word to word, so the key stream is consumed continuously.

Top module: `lfsr_word_scrambler`

## Requirements
- R1: Reset clears all six key registers, the CRC register and the output buffer. After reset `out_valid` is 0 and `in_ready` is 1. With an all-zero key, a word takes 32 steps with zero pad bits.
- R2: Configuration writes address one byte each, least significant byte at the lowest address of each register. The ranges are: pad0 at 0..19, pad1 at 21..41, pad2 at 42..62, pad3 at 63..83, injector at 84..87 and selector at 88..92. Address 20 and addresses above 92 change nothing. The top addresses of pad1, pad2 and pad3 keep only bit 0, bits 1:0 and bits 2:0 of the byte.
- R3: One advance of a register of width W shifts it left by one with 0 entering bit 0. If the bit that left position W-1 was 1, the register is XORed with its feedback constant. The pad polynomials are x^160+x^139+x^119+x^98+x^79+x^40+x^20+1, x^161+x^140+x^121+x^100+x^80+x^60+x^40+x^20+1, x^162+x^141+x^121+x^100+x^80+x^60+x^40+x^20+1 and x^163+x^142+x^122+x^102+x^82+x^61+x^41+x^20+1. The injector constant is 0x08210421 and the selector constant is 0x0408081041.
- R4: The step count of a word is {1, inj[30], inj[5], inj[9], inj[2], inj[27]} (32..63). It is taken from the injector value held when the fourth byte is accepted. In that same cycle the injector advances 39 times.
- R5: The tap index of a step is {sel[31], sel[3], sel[5], sel[19], sel[8]}. Index 0..31 picks, in order: p1[15], p0[37], p2[73], p3[99], p0[121], p1[130], p3[15], p2[9], p3[97], p2[140], p1[4], p0[88], p0[33], p1[75], p2[35], p3[155], p2[28], p1[150], p3[29], p0[144], p0[127], p1[125], p2[0], p3[5], p0[110], p3[87], p1[19], p2[82], p0[48], p1[47], p2[46], p3[51].
- R6: Each step shifts the CRC left with the tap bit entering bit 0, and XORs 0xB7602B21 when the old bit 31 was 1. All four pads and the selector then advance once. Pads and selector are never reset between words.
- R7: The first input byte of a word lands in CRC bits 31:24. The result leaves as bits 31:24 first and bits 7:0 last.
- R8: `out_valid` is 1 exactly while the output buffer holds data. A byte is removed on each cycle with `out_valid` high and `out_stop` low. While `out_stop` is high, `out_byte` and `out_valid` hold.
- R9: `in_ready` is 1 only while the block is collecting a word. After the fourth byte it stays 0 until all four result bytes are in the output buffer, including while a full buffer stalls them.
- R10: A configuration write to a register in the same cycle as that register's advance wins: the register takes its old value with the written byte replaced, and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 7 | Configuration byte address |
| cfg_byte | input | 8 | Configuration byte value |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input data byte |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_valid | output | 1 | Output buffer not empty |
| out_byte | output | 8 | Head byte of the output buffer |
| out_stop | input | 1 | Consumer holds off removal |

## Verification
Any wrong bit in a pad, the selector or the injector reaches the ports only through the scrambled bytes. That happens on the first step that selects the bad tap, or on the next word's step count. A fault can therefore hide for several words and then corrupt every word after it, because key state never resets. The bench runs a long stream of words across key loads and compares every output byte with an independent model. This way state drift shows up as a miscompare within the word where it first takes effect. Stalls, the write-versus-advance collision and ignored addresses are aimed at directly, because their effects appear only in later outputs.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int PAD_N    = 4;
    localparam int PAD_W0   = 160;
    localparam int PAD_WMAX = PAD_W0 + PAD_N - 1;
    localparam int PAD_SLOT = 21;
    localparam int WORD_W   = 32;
    localparam int INJ_W    = 32;
    localparam int SEL_W    = 40;
    localparam int ADDR_W   = 7;
    localparam int INJ_BASE = PAD_N * PAD_SLOT;
    localparam int SEL_BASE = INJ_BASE + INJ_W / 8;
    localparam int INJ_ADV  = 39;
    localparam int CNT_W    = 6;

    localparam logic [WORD_W-1:0] CRC_POLY = 32'hB760_2B21;
    localparam logic [INJ_W-1:0]  INJ_POLY = 32'h0821_0421;
    localparam logic [SEL_W-1:0]  SEL_POLY = 40'h04_0808_1041;

    typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_EMIT} phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [1:0]         cnt;
        logic [CNT_W-1:0]   steps;
        logic [WORD_W-1:0]  crc;
    } ctl_t;

    // feedback constant of pad g, low terms only (top term implied)
    function automatic logic [PAD_WMAX-1:0] pad_poly(input int g);
        logic [PAD_WMAX-1:0] p;
        p = '0;
        p[0] = 1'b1;
        p[20] = 1'b1;
        case (g)
            0: begin p[139]=1'b1; p[119]=1'b1; p[98]=1'b1; p[79]=1'b1; p[40]=1'b1; end
            1: begin p[140]=1'b1; p[121]=1'b1; p[100]=1'b1; p[80]=1'b1; p[60]=1'b1; p[40]=1'b1; end
            2: begin p[141]=1'b1; p[121]=1'b1; p[100]=1'b1; p[80]=1'b1; p[60]=1'b1; p[40]=1'b1; end
            default: begin p[142]=1'b1; p[122]=1'b1; p[102]=1'b1; p[82]=1'b1; p[61]=1'b1; p[41]=1'b1; end
        endcase
        return p;
    endfunction

    function automatic logic [CNT_W-1:0] step_count(input logic [INJ_W-1:0] inj);
        return {1'b1, inj[30], inj[5], inj[9], inj[2], inj[27]};
    endfunction

    function automatic logic [4:0] tap_index(input logic [SEL_W-1:0] sel);
        return {sel[31], sel[3], sel[5], sel[19], sel[8]};
    endfunction

    // pad g occupies pads[g*PAD_WMAX +: PAD_WMAX]
    function automatic logic tap_pick(input logic [4:0] idx,
                                      input logic [PAD_N*PAD_WMAX-1:0] pads);
        logic b;
        case (idx)
            5'd0:  b = pads[1*PAD_WMAX+15];
            5'd1:  b = pads[0*PAD_WMAX+37];
            5'd2:  b = pads[2*PAD_WMAX+73];
            5'd3:  b = pads[3*PAD_WMAX+99];
            5'd4:  b = pads[0*PAD_WMAX+121];
            5'd5:  b = pads[1*PAD_WMAX+130];
            5'd6:  b = pads[3*PAD_WMAX+15];
            5'd7:  b = pads[2*PAD_WMAX+9];
            5'd8:  b = pads[3*PAD_WMAX+97];
            5'd9:  b = pads[2*PAD_WMAX+140];
            5'd10: b = pads[1*PAD_WMAX+4];
            5'd11: b = pads[0*PAD_WMAX+88];
            5'd12: b = pads[0*PAD_WMAX+33];
            5'd13: b = pads[1*PAD_WMAX+75];
            5'd14: b = pads[2*PAD_WMAX+35];
            5'd15: b = pads[3*PAD_WMAX+155];
            5'd16: b = pads[2*PAD_WMAX+28];
            5'd17: b = pads[1*PAD_WMAX+150];
            5'd18: b = pads[3*PAD_WMAX+29];
            5'd19: b = pads[0*PAD_WMAX+144];
            5'd20: b = pads[0*PAD_WMAX+127];
            5'd21: b = pads[1*PAD_WMAX+125];
            5'd22: b = pads[2*PAD_WMAX+0];
            5'd23: b = pads[3*PAD_WMAX+5];
            5'd24: b = pads[0*PAD_WMAX+110];
            5'd25: b = pads[3*PAD_WMAX+87];
            5'd26: b = pads[1*PAD_WMAX+19];
            5'd27: b = pads[2*PAD_WMAX+82];
            5'd28: b = pads[0*PAD_WMAX+48];
            5'd29: b = pads[1*PAD_WMAX+47];
            5'd30: b = pads[2*PAD_WMAX+46];
            default: b = pads[3*PAD_WMAX+51];
        endcase
        return b;
    endfunction
endpackage

// File: rtl/scr_galois_reg.sv
module scr_galois_reg #(
    parameter int             W      = 32,
    parameter logic [W-1:0]   POLY   = '0,
    parameter int             BASE   = 0,
    parameter int             ADV    = 1,
    parameter int             ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_byte,
    input  logic              step,
    output logic [W-1:0]      q
);
    localparam int NB        = (W + 7) / 8;
    localparam int EXT       = NB * 8;
    localparam int SW        = $clog2(NB);
    localparam int LAST_BITS = W - 8 * (NB - 1);
    localparam logic [7:0] LAST_MASK = 8'((1 << LAST_BITS) - 1);

    int              slot;
    logic            hit;
    logic [SW-1:0]   slot_idx;
    logic [W-1:0]    adv;
    logic [EXT-1:0]  ext;
    logic [EXT-1:0]  q_ext;
    logic [W-1:0]    q_d, q_q;

    always_comb begin
        slot     = int'(cfg_addr) - BASE;
        hit      = cfg_we && (slot >= 0) && (slot < NB);
        slot_idx = slot[SW-1:0];
        adv      = q_q;
        for (int i = 0; i < ADV; i++)
            adv = {adv[W-2:0], 1'b0} ^ (adv[W-1] ? POLY : '0);
        q_ext         = '0;
        q_ext[W-1:0]  = q_q;
        ext           = q_ext;
        ext[{slot_idx, 3'b000} +: 8] = cfg_byte;
        // a byte write wins over an advance of the same register
        if (hit)       q_d = ext[W-1:0];
        else if (step) q_d = adv;
        else           q_d = q_q;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign q = q_q;

    assert_cfg_wins_R10: assert property (@(posedge clk) disable iff (rst)
        hit |=> (q_ext[{$past(slot_idx), 3'b000} +: 8] ==
                 ($past(cfg_byte) & (($past(slot_idx) == SW'(NB - 1)) ? LAST_MASK : 8'hFF))));

    assert_key_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!hit && !step) |=> $stable(q_q));
endmodule

// File: rtl/scr_byte_fifo.sv
module scr_byte_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] din,
    output logic       full,
    input  logic       stop,
    output logic       valid,
    output logic [7:0] dout
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wr;
        logic [AW-1:0]         rd;
        logic [AW:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  pop;

    always_comb begin
        f_d   = f_q;
        valid = (f_q.cnt != '0);
        full  = (f_q.cnt == (AW+1)'(DEPTH));
        pop   = valid && !stop;
        dout  = f_q.mem[f_q.rd];
        if (push) begin
            f_d.mem[f_q.wr] = din;
            f_d.wr          = f_q.wr + 1'b1;
        end
        if (pop) f_d.rd = f_q.rd + 1'b1;
        f_d.cnt = f_q.cnt + (AW+1)'(push) - (AW+1)'(pop);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> (f_q.cnt < (AW+1)'(DEPTH)) || pop);

    assert_stop_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && stop && !push) |=> (valid && $stable(dout)));

    assert_valid_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        (!valid && !push) |=> !valid);
endmodule

// File: rtl/lfsr_word_scrambler.sv
module lfsr_word_scrambler #(
    parameter int OUT_DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [scr_pkg::ADDR_W-1:0] cfg_addr,
    input  logic [7:0]             cfg_byte,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [7:0]             out_byte,
    input  logic                   out_stop
);
    import scr_pkg::*;

    ctl_t                          s_d, s_q;
    logic                          inj_adv, pad_step, fifo_push, fifo_full, tap;
    logic [INJ_W-1:0]              inj_q;
    logic [SEL_W-1:0]              sel_q;
    logic [PAD_N*PAD_WMAX-1:0]     pads_flat;

    for (genvar g = 0; g < PAD_N; g++) begin : g_pad
        localparam int PW = PAD_W0 + g;
        logic [PW-1:0] pq;
        scr_galois_reg #(.W(PW), .POLY(PW'(pad_poly(g))), .BASE(PAD_SLOT * g),
                         .ADV(1), .ADDR_W(ADDR_W)) u_pad (
            .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
            .cfg_byte(cfg_byte), .step(pad_step), .q(pq));
        assign pads_flat[g*PAD_WMAX +: PAD_WMAX] = PAD_WMAX'(pq);
    end

    scr_galois_reg #(.W(INJ_W), .POLY(INJ_POLY), .BASE(INJ_BASE),
                     .ADV(INJ_ADV), .ADDR_W(ADDR_W)) u_inj (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_byte(cfg_byte), .step(inj_adv), .q(inj_q));

    scr_galois_reg #(.W(SEL_W), .POLY(SEL_POLY), .BASE(SEL_BASE),
                     .ADV(1), .ADDR_W(ADDR_W)) u_sel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_byte(cfg_byte), .step(pad_step), .q(sel_q));

    scr_byte_fifo #(.DEPTH(OUT_DEPTH)) u_out (
        .clk(clk), .rst(rst), .push(fifo_push), .din(s_q.crc[WORD_W-1 -: 8]),
        .full(fifo_full), .stop(out_stop), .valid(out_valid), .dout(out_byte));

    always_comb begin
        s_d       = s_q;
        inj_adv   = 1'b0;
        pad_step  = 1'b0;
        fifo_push = 1'b0;
        in_ready  = (s_q.phase == PH_LOAD);
        tap       = tap_pick(tap_index(sel_q), pads_flat);
        case (s_q.phase)
            PH_LOAD: if (in_valid) begin
                s_d.crc = {s_q.crc[WORD_W-9:0], in_byte};
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == 2'd3) begin
                    s_d.phase = PH_RUN;
                    s_d.steps = step_count(inj_q);
                    inj_adv   = 1'b1;
                end
            end
            PH_RUN: begin
                pad_step  = 1'b1;
                s_d.crc   = {s_q.crc[WORD_W-2:0], tap} ^ (s_q.crc[WORD_W-1] ? CRC_POLY : '0);
                s_d.steps = s_q.steps - 1'b1;
                if (s_q.steps == CNT_W'(1)) begin
                    s_d.phase = PH_EMIT;
                    s_d.cnt   = 2'd0;
                end
            end
            PH_EMIT: if (!fifo_full) begin
                fifo_push = 1'b1;
                s_d.crc   = {s_q.crc[WORD_W-9:0], 8'h00};
                s_d.cnt   = s_q.cnt + 1'b1;
                if (s_q.cnt == 2'd3) s_d.phase = PH_LOAD;
            end
            default: s_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // bytes taken in minus bytes handed to the buffer
    logic [3:0] chk_inflight;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) chk_inflight <= '0;
        else     chk_inflight <= chk_inflight + 4'(in_valid && in_ready) - 4'(fifo_push);
    end

    assert_hold_input_R9: assert property (@(posedge clk) disable iff (rst)
        chk_inflight <= 4'd4);

    assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (chk_inflight == 4'd4) |-> !in_ready);

    assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_RUN && $past(s_q.phase) == PH_LOAD) |-> s_q.steps[CNT_W-1]);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_full);
endmodule

// File: tb/tb_lfsr_word_scrambler.sv
module tb_lfsr_word_scrambler;
    localparam int CLK_PERIOD = 10;
    localparam int WMAX = 163;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0, in_valid = 1'b0, out_stop = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_byte = '0, in_byte = '0;
    logic in_ready, out_valid;
    logic [7:0] out_byte;

    int n_checks = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // model key state: 0..3 pads, 4 injector, 5 selector
    logic [WMAX-1:0] mreg [6];
    logic [WMAX-1:0] mpoly[6];
    int mw[6]   = '{160, 161, 162, 163, 32, 40};
    int mbase[6] = '{0, 21, 42, 63, 84, 88};
    logic [31:0] lcg = 32'h1234_5678;

    lfsr_word_scrambler dut (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_byte(cfg_byte), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_byte(out_byte), .out_stop(out_stop));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [WMAX-1:0] pb(int a, int b, int c, int d, int e, int f, int g, int h);
        logic [WMAX-1:0] p = '0;
        int t[8] = '{a, b, c, d, e, f, g, h};
        foreach (t[i]) if (t[i] >= 0) p[t[i]] = 1'b1;
        return p;
    endfunction

    function automatic logic [WMAX-1:0] gstep(logic [WMAX-1:0] v, int r);
        logic top = v[mw[r]-1];
        logic [WMAX-1:0] x = v << 1;
        for (int i = mw[r]; i < WMAX; i++) x[i] = 1'b0;
        if (top) x = x ^ mpoly[r];
        return x;
    endfunction

    function automatic logic mtap(logic [4:0] k);
        case (k)
            0: return mreg[1][15];   1: return mreg[0][37];   2: return mreg[2][73];   3: return mreg[3][99];
            4: return mreg[0][121];  5: return mreg[1][130];  6: return mreg[3][15];   7: return mreg[2][9];
            8: return mreg[3][97];   9: return mreg[2][140];  10: return mreg[1][4];   11: return mreg[0][88];
            12: return mreg[0][33];  13: return mreg[1][75];  14: return mreg[2][35];  15: return mreg[3][155];
            16: return mreg[2][28];  17: return mreg[1][150]; 18: return mreg[3][29];  19: return mreg[0][144];
            20: return mreg[0][127]; 21: return mreg[1][125]; 22: return mreg[2][0];   23: return mreg[3][5];
            24: return mreg[0][110]; 25: return mreg[3][87];  26: return mreg[1][19];  27: return mreg[2][82];
            28: return mreg[0][48];  29: return mreg[1][47];  30: return mreg[2][46];  default: return mreg[3][51];
        endcase
    endfunction

    function automatic void mcfg(int a, logic [7:0] b);
        for (int r = 0; r < 6; r++)
            if (a >= mbase[r] && a < mbase[r] + (mw[r] + 7) / 8)
                for (int i = 0; i < 8; i++)
                    if (8 * (a - mbase[r]) + i < mw[r]) mreg[r][8 * (a - mbase[r]) + i] = b[i];
    endfunction

    // model one word; when hold_inj the injector skips its advance (write collision)
    function automatic void mword(logic [31:0] w, string tag, bit hold_inj);
        logic [31:0] crc = w;
        logic [WMAX-1:0] inj = mreg[4];
        int cnt = {1'b1, inj[30], inj[5], inj[9], inj[2], inj[27]};
        if (!hold_inj) for (int i = 0; i < 39; i++) mreg[4] = gstep(mreg[4], 4);
        for (int s = 0; s < cnt; s++) begin
            logic [WMAX-1:0] ps = mreg[5];
            logic bit_in = mtap({ps[31], ps[3], ps[5], ps[19], ps[8]});
            logic msb = crc[31];
            crc = {crc[30:0], bit_in};
            if (msb) crc = crc ^ 32'hB760_2B21;
            for (int r = 0; r < 4; r++) mreg[r] = gstep(mreg[r], r);
            mreg[5] = gstep(mreg[5], 5);
        end
        for (int k = 3; k >= 0; k--) begin
            exp_q.push_back(crc[8*k +: 8]);
            tag_q.push_back(tag);
        end
    endfunction

    task automatic cfg_write(int a, logic [7:0] b);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_byte = b;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        void'(mcfg(a, b));
    endtask

    // driver: sends a word, optionally with a config write on the fourth byte
    task automatic send_word(logic [31:0] w, string tag, bit col = 0, int ca = 0, logic [7:0] cb = 0);
        logic acc;
        mword(w, tag, col);
        if (col) void'(mcfg(ca, cb));
        for (int k = 3; k >= 0; k--) begin
            in_valid = 1'b1; in_byte = w[8*k +: 8];
            if (k == 0 && col) begin cfg_we = 1'b1; cfg_addr = 7'(ca); cfg_byte = cb; end
            do begin
                @(negedge clk); acc = in_ready;
                @(posedge clk); #1;
            end while (!acc);
            cfg_we = 1'b0;
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_drained();
        int guard = 0;
        while ((exp_q.size() != 0 || !in_ready) && guard < 5000) begin
            @(posedge clk); #1; guard++;
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // monitor: removal happens at the next edge when valid and not stopped
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid && !out_stop) begin
                if (exp_q.size() == 0) check("R8 unexpected byte", {24'h0, out_byte}, 32'hFFFF_FFFF);
                else check(tag_q.pop_front(), {24'h0, out_byte}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        mpoly[0] = pb(139, 119, 98, 79, 40, 20, 0, -1);
        mpoly[1] = pb(140, 121, 100, 80, 60, 40, 20, 0);
        mpoly[2] = pb(141, 121, 100, 80, 60, 40, 20, 0);
        mpoly[3] = pb(142, 122, 102, 82, 61, 41, 20, 0);
        mpoly[4] = pb(27, 21, 16, 10, 5, 0, -1, -1);
        mpoly[5] = pb(34, 27, 19, 12, 6, 0, -1, -1);
        foreach (mreg[i]) mreg[i] = '0;

        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
        @(posedge clk); #1;

        // all-zero key
        send_word(32'h1234_5678, "R1 zero key word");
        send_word(32'h8000_0001, "R7 byte order word");
        wait_drained();

        // full key load with pseudo-random bytes, plus ignored addresses
        for (int a = 0; a < 93; a++) cfg_write(a, rnd() >> 8);
        cfg_write(20, 8'hA5);
        cfg_write(100, 8'h3C);
        cfg_write(41, 8'hFF);
        cfg_write(62, 8'hFE);
        cfg_write(83, 8'hFB);
        send_word(32'hDEAD_BEEF, "R2 map and masking");
        send_word(32'h0000_0000, "R3 register stepping");
        send_word(32'hFFFF_FFFF, "R4 step count");
        send_word(32'hA5A5_5A5A, "R5 tap table");
        send_word(32'h0F1E_2D3C, "R6 key carry-over");
        wait_drained();

        // back-pressure: buffer of 8 fills after two words, third stalls
        out_stop = 1'b1;
        send_word(32'h0102_0304, "R8 stalled word A");
        send_word(32'h1122_3344, "R8 stalled word B");
        send_word(32'h5566_7788, "R9 stalled word C");
        repeat (150) @(posedge clk);
        @(negedge clk);
        held = out_byte;
        check("R9 in_ready low while stalled", {31'b0, in_ready}, 32'd0);
        check("R8 out_valid while stopped", {31'b0, out_valid}, 32'd1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8 out_byte held under stop", {24'h0, out_byte}, {24'h0, held});
        @(posedge clk); #1;
        out_stop = 1'b0;
        wait_drained();

        // write to the injector in the cycle its advance would occur
        send_word(32'hCAFE_F00D, "R10 collision word", 1, 85, 8'h5B);
        send_word(32'h7654_3210, "R10 following word");
        wait_drained();

        // stream with intermittent stop
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    @(posedge clk); #1;
                    out_stop = rnd()[20];
                end
                out_stop = 1'b0;
            end
            begin
                for (int i = 0; i < 6; i++) send_word(rnd(), "R6 streamed word");
            end
        join
        out_stop = 1'b0;
        wait_drained();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 buffer empty at end", {31'b0, out_valid}, 32'd0);
        check("R8 all bytes delivered", exp_q.size(), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule